// File: doc/BRIEF.md
# Pitch Modulation Oscillator with Exponential Rate Multiplier

This block is a per-voice low-frequency oscillator that bends pitch. It holds an 8-bit oscillator phase that advances once every few audio samples. A rate counter reloads from a programmable value and sets how many samples pass between steps. The phase is turned into one of four waveforms: ramp, square, triangle or a scrambled pseudo-noise pattern. That 8-bit waveform value, read as a signed number, selects an entry from a multiplier table. The table holds factors with 10 fractional bits that follow an exponential curve in cents, and the depth select chooses how wide the curve is.

The voice's base phase increment is multiplied by the registered factor and shifted right by 10 bits. The result is the increment the sample player should use for the current sample. When the depth is zero, the multiplier is exactly one and the increment passes through unchanged.

Top module: `pitchLfo`

## Requirements
- R1: After reset, `lfoPhase` is 0 and `multOut` is 1024, which is unity.
- R2: After `lfoReset` with `reloadVal` R ≥ 1, `lfoPhase` rises by one on the R-th `sampleStb` and then on every R-th strobe after that. With R = 0, every strobe advances the phase. The first strobe after power-on reset advances it.
- R3: `lfoReset` clears `lfoPhase` to 0 and reloads the rate counter in the next cycle, and it takes priority over a strobe in the same cycle.
- R4: The phase counts modulo 256, so 255 is followed by 0.
- R5: `waveSel` = 0 selects the ramp waveform, whose value equals the phase.
- R6: `waveSel` = 1 selects the square waveform: 255 when phase bit 7 is 1, otherwise 0.
- R7: `waveSel` = 2 selects the triangle waveform: the low 7 phase bits, inverted when bit 7 is set, then shifted left by one.
- R8: `waveSel` = 3 selects the noise waveform, the low 8 bits of (phase>>3) ^ (phase<<3) ^ (phase & 0xE3).
- R9: `multOut` equals trunc(1024·2^(c·i/153600)). Here i is the waveform value taken as a signed 8-bit number. c is the cent value picked by `depthSel` 0..7: 0, 3.61, 7.22, 14.44, 28.88, 57.75, 115.5, 231.
- R10: `multOut` is registered. It follows the phase, waveform and depth of the previous cycle, so a phase step shows on `multOut` one cycle after it shows on `lfoPhase`.
- R11: `scaledInc` equals (`baseInc` × `multOut`) >> 10, computed combinationally from the current `baseInc`.
- R12: In a cycle without `sampleStb` or `lfoReset`, the phase does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStb | input | 1 | One pulse per audio sample |
| lfoReset | input | 1 | Clears the phase and reloads the rate counter |
| reloadVal | input | RateW | Samples per phase step |
| waveSel | input | 2 | Waveform: 0 ramp, 1 square, 2 triangle, 3 noise |
| depthSel | input | 3 | Modulation depth index |
| baseInc | input | IncW | Unmodulated phase increment |
| lfoPhase | output | 8 | Oscillator phase |
| multOut | output | 12 | Registered multiplier, 10 fractional bits |
| scaledInc | output | IncW+2 | Modulated phase increment |

## Verification
The assertions assume that `sampleStb` and `lfoReset` are clean synchronous pulses. They also assume that `depthSel` stays in range, so `multOut` stays inside the narrow band around 1024 that the deepest table spans. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It changes waveform and depth only while the phase is parked, so each sampled multiplier comes from one known phase, waveform and depth.

// File: rtl/pitchLfoPkg.sv
package pitchLfoPkg;
  localparam int PhaseW = 8;
  localparam int MulW = 12;
  localparam int FracW = 10;
  localparam int DepthN = 8;
  localparam int TableN = 2 ** PhaseW;

  typedef enum logic [1:0] {
    WaveRamp   = 2'd0,
    WaveSquare = 2'd1,
    WaveTri    = 2'd2,
    WaveNoise  = 2'd3
  } waveKind_e;

  // strobes from the rate control to the phase datapath
  typedef struct packed {
    logic clearPhase;
    logic stepPhase;
  } phaseCmd_t;

  function automatic real depthCents(input int d);
    case (d)
      1: return 3.61;
      2: return 7.22;
      3: return 14.44;
      4: return 28.88;
      5: return 57.75;
      6: return 115.5;
      7: return 231.0;
      default: return 0.0;
    endcase
  endfunction

  // entry k of table d stands for signed waveform value k-128
  function automatic logic [MulW-1:0] mulEntry(input int d, input int k);
    real c;
    real e;
    c = depthCents(d);
    e = $pow(2.0, c * real'(k - 128) / 128.0 / 1200.0) * 1024.0;
    return MulW'($rtoi(e));
  endfunction

  function automatic logic [PhaseW-1:0] waveValue(input waveKind_e kind,
                                                  input logic [PhaseW-1:0] ph);
    case (kind)
      WaveSquare: return ph[PhaseW-1] ? '1 : '0;
      WaveTri:    return {ph[PhaseW-2:0] ^ {(PhaseW-1){ph[PhaseW-1]}}, 1'b0};
      WaveNoise:  return (ph >> 3) ^ (ph << 3) ^ (ph & 8'hE3);
      default:    return ph;
    endcase
  endfunction
endpackage

// File: rtl/pitchLfoCtrl.sv
module pitchLfoCtrl
  import pitchLfoPkg::*;
#(
  parameter int RateW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleStb,
  input  logic             lfoReset,
  input  logic [RateW-1:0] reloadVal,
  output phaseCmd_t        cmd
);
  logic [RateW-1:0] rateCnt;
  logic expire;

  assign expire = (rateCnt <= RateW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateCnt <= '0;
    end else if (lfoReset) begin
      rateCnt <= reloadVal;
    end else if (sampleStb) begin
      rateCnt <= expire ? reloadVal : rateCnt - RateW'(1);
    end
  end

  always_comb begin
    cmd.clearPhase = lfoReset;
    cmd.stepPhase  = sampleStb && expire && !lfoReset;
  end
endmodule

// File: rtl/pitchLfoDatapath.sv
module pitchLfoDatapath
  import pitchLfoPkg::*;
#(
  parameter int IncW = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  phaseCmd_t                  cmd,
  input  logic [1:0]                 waveSel,
  input  logic [2:0]                 depthSel,
  input  logic [IncW-1:0]            baseInc,
  output logic [PhaseW-1:0]          lfoPhase,
  output logic [MulW-1:0]            multOut,
  output logic [IncW+MulW-FracW-1:0] scaledInc
);
  localparam int RomN = DepthN * TableN;
  localparam int IdxW = $clog2(RomN);
  localparam logic [MulW-1:0] Unity = MulW'(1 << FracW);

  logic [PhaseW-1:0]    phaseReg;
  logic [PhaseW-1:0]    waveVal;
  logic [IdxW-1:0]      romIdx;
  logic [MulW-1:0]      romTable [RomN];
  logic [MulW-1:0]      multReg;
  logic [IncW+MulW-1:0] product;

  for (genvar d = 0; d < DepthN; d++) begin : gDepth
    for (genvar k = 0; k < TableN; k++) begin : gEntry
      assign romTable[d*TableN + k] = mulEntry(d, k);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseReg <= '0;
    end else if (cmd.clearPhase) begin
      phaseReg <= '0;
    end else if (cmd.stepPhase) begin
      phaseReg <= phaseReg + PhaseW'(1);
    end
  end

  assign waveVal = waveValue(waveKind_e'(waveSel), phaseReg);
  // signed value i maps to table slot i+128: flip the sign bit
  assign romIdx = {depthSel, ~waveVal[PhaseW-1], waveVal[PhaseW-2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      multReg <= Unity;
    end else begin
      multReg <= romTable[romIdx];
    end
  end

  assign product   = baseInc * multReg;
  assign scaledInc = product[IncW+MulW-1:FracW];
  assign lfoPhase  = phaseReg;
  assign multOut   = multReg;
endmodule

// File: rtl/pitchLfo.sv
module pitchLfo
  import pitchLfoPkg::*;
#(
  parameter int RateW = 16,
  parameter int IncW  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleStb,
  input  logic             lfoReset,
  input  logic [RateW-1:0] reloadVal,
  input  logic [1:0]       waveSel,
  input  logic [2:0]       depthSel,
  input  logic [IncW-1:0]  baseInc,
  output logic [7:0]       lfoPhase,
  output logic [11:0]      multOut,
  output logic [IncW+1:0]  scaledInc
);
  phaseCmd_t cmd;

  pitchLfoCtrl #(.RateW(RateW)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .lfoReset(lfoReset),
    .reloadVal(reloadVal), .cmd(cmd)
  );

  pitchLfoDatapath #(.IncW(IncW)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .waveSel(waveSel), .depthSel(depthSel),
    .baseInc(baseInc), .lfoPhase(lfoPhase), .multOut(multOut), .scaledInc(scaledInc)
  );
endmodule

// File: rtl/pitchLfoChecker.sv
module pitchLfoChecker #(
  parameter int IncW = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            sampleStb,
  input logic            lfoReset,
  input logic [2:0]      depthSel,
  input logic [IncW-1:0] baseInc,
  input logic [7:0]      lfoPhase,
  input logic [11:0]     multOut,
  input logic [IncW+1:0] scaledInc
);
  assert_reset_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    lfoReset |=> (lfoPhase == 8'd0));

  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleStb && !lfoReset) |=> $stable(lfoPhase));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && !lfoReset) |=>
      (lfoPhase == $past(lfoPhase) || lfoPhase == $past(lfoPhase) + 8'd1));

  assert_flat_depth_R9: assert property (@(posedge clk) disable iff (!rstN)
    (depthSel == 3'd0) |=> (multOut == 12'd1024));

  assert_mult_band_R9: assert property (@(posedge clk) disable iff (!rstN)
    (multOut >= 12'd896 && multOut <= 12'd1170));

  assert_unity_pass_R11: assert property (@(posedge clk) disable iff (!rstN)
    (multOut == 12'd1024) |-> (scaledInc == (IncW+2)'(baseInc)));
endmodule

bind pitchLfo pitchLfoChecker #(.IncW(IncW)) uChk (
  .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .lfoReset(lfoReset),
  .depthSel(depthSel), .baseInc(baseInc), .lfoPhase(lfoPhase),
  .multOut(multOut), .scaledInc(scaledInc)
);

// File: tb/tb_pitchLfo.sv
`timescale 1ns/1ps
module tb_pitchLfo;
  localparam int RateW = 16;
  localparam int IncW  = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             sampleStb = 1'b0;
  logic             lfoReset = 1'b0;
  logic [RateW-1:0] reloadVal = '0;
  logic [1:0]       waveSel = 2'd0;
  logic [2:0]       depthSel = 3'd0;
  logic [IncW-1:0]  baseInc = '0;
  logic [7:0]       lfoPhase;
  logic [11:0]      multOut;
  logic [IncW+1:0]  scaledInc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pitchLfo #(.RateW(RateW), .IncW(IncW)) dut (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .lfoReset(lfoReset),
    .reloadVal(reloadVal), .waveSel(waveSel), .depthSel(depthSel),
    .baseInc(baseInc), .lfoPhase(lfoPhase), .multOut(multOut), .scaledInc(scaledInc)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic real centsFor(input int d);
    real tbl [8];
    tbl = '{0.0, 3.61, 7.22, 14.44, 28.88, 57.75, 115.5, 231.0};
    return tbl[d];
  endfunction

  function automatic logic [7:0] modelWave(input int sel, input logic [7:0] s);
    logic [7:0] t;
    case (sel)
      0: return s;
      1: return s[7] ? 8'hFF : 8'h00;
      2: begin
        t = s & 8'h7F;
        if (s[7]) t = t ^ 8'h7F;
        return t << 1;
      end
      default: return ((s >> 3) ^ (s << 3) ^ (s & 8'hE3));
    endcase
  endfunction

  function automatic int modelMul(input int d, input logic [7:0] w);
    real e;
    int i;
    i = int'($signed(w));
    e = $pow(2.0, centsFor(d) * real'(i) / 128.0 / 1200.0) * 1024.0;
    return $rtoi(e);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic strobe();
    sampleStb = 1'b1;
    tick();
    sampleStb = 1'b0;
  endtask

  task automatic restartLfo(input int reload);
    reloadVal = RateW'(reload);
    lfoReset = 1'b1;
    tick();
    lfoReset = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 phase", lfoPhase, 0);
    chk("R1 mult", multOut, 1024);
  endtask

  task automatic testRate();
    restartLfo(3);
    chk("R3 cleared", lfoPhase, 0);
    strobe(); chk("R2 r3 s1", lfoPhase, 0);
    strobe(); chk("R2 r3 s2", lfoPhase, 0);
    strobe(); chk("R2 r3 s3", lfoPhase, 1);
    tick(); tick();
    chk("R12 idle gap", lfoPhase, 1);
    strobe(); strobe(); chk("R2 r3 s5", lfoPhase, 1);
    strobe(); chk("R2 r3 s6", lfoPhase, 2);
    restartLfo(0);
    for (int n = 1; n <= 5; n++) begin
      strobe(); chk("R2 reload0", lfoPhase, n);
    end
    // reset together with a strobe: reset wins
    reloadVal = RateW'(1);
    lfoReset = 1'b1; sampleStb = 1'b1;
    tick();
    lfoReset = 1'b0; sampleStb = 1'b0;
    chk("R3 priority", lfoPhase, 0);
    strobe(); chk("R3 reload after", lfoPhase, 1);
  endtask

  task automatic testWave(input int sel, input string req);
    waveSel = 2'(sel);
    depthSel = 3'd7;
    restartLfo(1);
    tick();
    for (int p = 0; p < 256; p++) begin
      int expNow;
      expNow = modelMul(7, modelWave(sel, 8'(p)));
      chk(req, lfoPhase, p);
      chk(req, multOut, expNow);
      strobe();
      chk("R10 lag", multOut, expNow);
      tick();
    end
    chk("R4 wrap", lfoPhase, 0);
  endtask

  task automatic testDepths();
    waveSel = 2'd0;
    restartLfo(1);
    for (int n = 0; n < 200; n++) strobe();
    for (int d = 0; d < 8; d++) begin
      depthSel = 3'(d);
      tick();
      chk("R9 depth hi", multOut, modelMul(d, 8'd200));
    end
    restartLfo(1);
    for (int n = 0; n < 127; n++) strobe();
    for (int d = 0; d < 8; d++) begin
      depthSel = 3'(d);
      tick();
      chk("R9 depth lo", multOut, modelMul(d, 8'd127));
    end
  endtask

  task automatic testScale();
    longint m;
    depthSel = 3'd0;
    baseInc = 16'd12345;
    tick();
    chk("R11 unity", scaledInc, 12345);
    depthSel = 3'd7;
    waveSel = 2'd0;
    restartLfo(1);
    for (int n = 0; n < 127; n++) strobe();
    tick();
    m = modelMul(7, 8'd127);
    baseInc = 16'hFFFF;
    #1;
    chk("R11 max up", scaledInc, (longint'(16'hFFFF) * m) >>> 10);
    restartLfo(1);
    for (int n = 0; n < 128; n++) strobe();
    tick();
    m = modelMul(7, 8'd128);
    baseInc = 16'd40000;
    #1;
    chk("R11 max down", scaledInc, (longint'(40000) * m) >>> 10);
  endtask

  task automatic testHold();
    restartLfo(1);
    strobe(); strobe();
    for (int n = 0; n < 10; n++) begin
      waveSel = 2'(n);
      tick();
      chk("R12 hold", lfoPhase, 2);
    end
  endtask

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    testReset();
    testRate();
    testWave(0, "R5 ramp");
    testWave(1, "R6 square");
    testWave(2, "R7 triangle");
    testWave(3, "R8 noise");
    testDepths();
    testScale();
    testHold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule